// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This unit performs 32-bit integer division for a processor execute stage. Each operation picks signed or unsigned mode, and the unit returns a quotient and a remainder. A single-cycle start pulse captures two operands and a mode bit. The unit then works out how many quotient bits can be non-zero. From the leading-zero counts of the two magnitudes it aligns the divisor, and it resolves three quotient bits per clock.

Operands of similar size finish quickly. A wide gap between their most significant set bits takes longer, up to twelve cycles at most. Zero divisors and divisors larger than the dividend take a short fixed path. An abort input lets interrupt entry cancel an operation in flight. The partial result is then thrown away and no completion pulse appears, so the operation can simply be reissued later.

Top module: `qdiv_unit`

## Requirements
- R1: In unsigned mode (`signed_op`=0), with a non-zero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor.
- R2: In signed mode (`signed_op`=1), both operands are read as two's complement. The quotient is truncated toward zero, and the non-zero remainder takes the sign of the dividend.
- R3: A signed division of 0x80000000 by 0xFFFFFFFF (-1) returns quotient 0x80000000 and remainder 0.
- R4: Let Ln and Ld be the bit lengths of the dividend and divisor magnitudes, where bit length is the position of the highest set bit plus one. For a non-early operation, `done` rises exactly (Ln-Ld)/3+2 clock edges after the edge that samples `start`, using integer division. Every operation takes between 2 and 12 edges.
- R5: When the divisor magnitude is zero or larger than the dividend magnitude, the result is quotient 0 with the remainder equal to the dividend, after 2 edges. No error is signalled.
- R6: `abort` sampled high at an edge while `busy` is high ends the operation. `busy` is low after that edge, no `done` pulse follows, and `quotient`/`remainder` keep their earlier values.
- R7: A start issued after an abort computes the correct result from the operands given with that start.
- R8: `start` sampled while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` is a one-cycle pulse, and `busy` is low in the `done` cycle, so a new start may be accepted there.
- R10: After reset, `busy`, `done`, `quotient` and `remainder` are 0. `quotient` and `remainder` change only on a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the current operands |
| signed_op | input | 1 | 1 = two's complement division, 0 = unsigned |
| dividend | input | 32 | Numerator operand |
| divisor | input | 32 | Denominator operand |
| abort | input | 1 | Cancel the operation in progress |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result registers updated |
| quotient | output | 32 | Quotient of the last completed operation |
| remainder | output | 32 | Remainder of the last completed operation |

## Verification
The bench builds the unit with its default parameters: a 32-bit width, three quotient bits per step, and the remainder output present. With these values the full range of alignment distances can be reached. That includes the 31-bit gap that gives the 12-cycle worst case, the most-negative-by-minus-one case in signed mode, and remainder sign checking on every operation. Operand magnitudes are also randomly thinned by right shifts, so every step count from one to eleven occurs.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_FIX  = 2'd2
  } qdiv_state_e;
endpackage

// File: rtl/qdiv_prep.sv
module qdiv_prep #(
  parameter int W  = 32,
  parameter int DB = 3,
  parameter int CW = 6,
  parameter int SW = 4
) (
  input  logic [W-1:0]  num,
  input  logic [W-1:0]  den,
  input  logic          sgn,
  output logic [W-1:0]  mag_n,
  output logic [W-1:0]  den_aligned,
  output logic          neg_q,
  output logic          neg_r,
  output logic          early,
  output logic [SW-1:0] steps
);
  logic [W-1:0]  mag_d;
  logic [CW-1:0] lz_n, lz_d, gap, align;

  always_comb begin
    mag_n = (sgn && num[W-1]) ? -num : num;
    mag_d = (sgn && den[W-1]) ? -den : den;
    lz_n  = CW'(W);
    lz_d  = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (mag_n[i]) lz_n = CW'(W - 1 - i);
      if (mag_d[i]) lz_d = CW'(W - 1 - i);
    end
    early       = (mag_d == '0) || (mag_d > mag_n);
    gap         = early ? '0 : (lz_d - lz_n);
    align       = gap - (gap % CW'(DB));
    steps       = SW'(gap / CW'(DB)) + SW'(1);
    den_aligned = mag_d << align;
    neg_q       = sgn & (num[W-1] ^ den[W-1]);
    neg_r       = sgn & num[W-1];
  end
endmodule

// File: rtl/qdiv_step.sv
module qdiv_step #(
  parameter int W  = 32,
  parameter int DB = 3
) (
  input  logic [W-1:0]  rem,
  input  logic [W-1:0]  dsh,
  output logic [DB-1:0] digit,
  output logic [W-1:0]  rem_nx
);
  localparam int NM = (1 << DB) - 1;
  localparam int XW = W + DB;

  logic [XW-1:0] mult [0:NM];
  logic [NM-1:0] ge;

  assign mult[0] = '0;

  generate
    for (genvar m = 1; m <= NM; m++) begin : g_mul
      assign mult[m]  = XW'(dsh) * XW'(m);
      assign ge[m-1]  = ({{DB{1'b0}}, rem} >= mult[m]);
    end
  endgenerate

  assign digit  = DB'($countones(ge));
  assign rem_nx = rem - mult[digit][W-1:0];
endmodule

// File: rtl/qdiv_fix.sv
module qdiv_fix #(
  parameter int W       = 32,
  parameter bit HAS_REM = 1'b1
) (
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         zero,
  output logic [W-1:0] q_fin,
  output logic [W-1:0] r_fin
);
  assign q_fin = zero ? '0 : (neg_q ? -quo : quo);

  generate
    if (HAS_REM) begin : g_rem
      assign r_fin = neg_r ? -rem : rem;
    end else begin : g_norem
      assign r_fin = '0;
    end
  endgenerate
endmodule

// File: rtl/qdiv_unit.sv
module qdiv_unit #(
  parameter int W       = 32,
  parameter int DB      = 3,
  parameter bit HAS_REM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         abort,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  import qdiv_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam int SW = $clog2((W - 1) / DB + 2);

  qdiv_state_e   st;
  logic [W-1:0]  rem_q, quo_q, dsh_q;
  logic [SW-1:0] cnt_q;
  logic          negq_q, negr_q, zero_q;

  logic [W-1:0]  p_mag, p_dsh;
  logic          p_negq, p_negr, p_early;
  logic [SW-1:0] p_steps;
  logic [DB-1:0] digit;
  logic [W-1:0]  rem_nx, q_fin, r_fin;

  qdiv_prep #(.W(W), .DB(DB), .CW(CW), .SW(SW)) u_prep (
    .num(dividend), .den(divisor), .sgn(signed_op),
    .mag_n(p_mag), .den_aligned(p_dsh),
    .neg_q(p_negq), .neg_r(p_negr), .early(p_early), .steps(p_steps)
  );

  qdiv_step #(.W(W), .DB(DB)) u_step (
    .rem(rem_q), .dsh(dsh_q), .digit(digit), .rem_nx(rem_nx)
  );

  qdiv_fix #(.W(W), .HAS_REM(HAS_REM)) u_fix (
    .quo(quo_q), .rem(rem_q), .neg_q(negq_q), .neg_r(negr_q),
    .zero(zero_q), .q_fin(q_fin), .r_fin(r_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rem_q     <= '0;
      quo_q     <= '0;
      dsh_q     <= '0;
      cnt_q     <= '0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      zero_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            rem_q  <= p_mag;
            quo_q  <= '0;
            dsh_q  <= p_dsh;
            cnt_q  <= p_steps;
            negq_q <= p_negq;
            negr_q <= p_negr;
            zero_q <= p_early;
            busy   <= 1'b1;
            st     <= ST_LOOP;
          end
        end
        ST_LOOP: begin
          if (abort) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            if (!zero_q) begin
              rem_q <= rem_nx;
              quo_q <= {quo_q[W-DB-1:0], digit};
              dsh_q <= dsh_q >> DB;
            end
            cnt_q <= cnt_q - SW'(1);
            if (cnt_q == SW'(1)) st <= ST_FIX;
          end
        end
        ST_FIX: begin
          busy <= 1'b0;
          st   <= ST_IDLE;
          if (!abort) begin
            quotient  <= q_fin;
            remainder <= r_fin;
            done      <= 1'b1;
          end
        end
        default: begin
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/qdiv_chk.sv
module qdiv_chk #(
  parameter int W  = 32,
  parameter int DB = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         abort,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int MAXL = (W - 1) / DB + 2;

  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (!busy) run_len <= '0;
    else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
  end

  // R9: an accepted start raises busy
  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done follows a busy cycle and busy is low with it
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  // R6: abort while busy ends the operation with no completion
  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> (!busy && !done));

  // R10: results change only with a done pulse
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R4: never more than the worst-case cycle count
  p_lat_max_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < 8'(MAXL)));

  // R4: never fewer than two cycles
  p_lat_min_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len >= 8'd2));
endmodule

bind qdiv_unit qdiv_chk #(.W(W), .DB(DB)) u_chk (
  .clk(clk), .rst(rst), .start(start), .abort(abort), .busy(busy),
  .done(done), .quotient(quotient), .remainder(remainder)
);

// File: tb/qdiv_unit_tb.sv
`timescale 1ns/1ps
module qdiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, signed_op = 1'b0, abort = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int checks = 0, errors = 0, cyc = 0;
  string req = "R10";

  // reference model state
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [31:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
  int          m_left = 0;

  always #2 clk = ~clk;

  qdiv_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .signed_op(signed_op),
    .dividend(dividend), .divisor(divisor), .abort(abort),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  function automatic int bitlen(input longint v);
    int n = 0;
    for (int i = 0; i < 33; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic ref_calc(input logic [31:0] a, input logic [31:0] b, input logic s,
                          output logic [31:0] q, output logic [31:0] r, output int lat);
    longint na, nb, ma, mb;
    na = s ? longint'($signed(a)) : longint'({32'b0, a});
    nb = s ? longint'($signed(b)) : longint'({32'b0, b});
    ma = (na < 0) ? -na : na;
    mb = (nb < 0) ? -nb : nb;
    if (mb == 0 || mb > ma) begin
      q = '0; r = a; lat = 2;
    end else begin
      q = 32'(na / nb);
      r = 32'(na % nb);
      lat = (bitlen(ma) - bitlen(mb)) / 3 + 2;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_q = '0; m_r = '0; m_left = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (abort) m_busy = 1'b0;
        else begin
          m_left--;
          if (m_left == 0) begin
            m_busy = 1'b0; m_done = 1'b1; m_q = p_q; m_r = p_r;
          end
        end
      end else if (start) begin
        ref_calc(dividend, divisor, signed_op, p_q, p_r, m_left);
        m_busy = 1'b1;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("busy", {31'b0, busy}, {31'b0, m_busy});
      chk("done", {31'b0, done}, {31'b0, m_done});
      chk("quotient", quotient, m_q);
      chk("remainder", remainder, m_r);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    dividend = a; divisor = b; signed_op = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("reset busy", {31'b0, busy}, 32'd0);
    chk("reset done", {31'b0, done}, 32'd0);
    chk("reset quotient", quotient, 32'd0);
    chk("reset remainder", remainder, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    req = "R1";
    run_op(32'd100, 32'd7, 1'b0);
    run_op(32'hFFFF_FFFF, 32'd3, 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0);

    req = "R4";
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0);   // 31-bit gap: 12 cycles
    run_op(32'd5, 32'd5, 1'b0);           // same size: 2 cycles
    run_op(32'd64, 32'd8, 1'b0);

    req = "R2";
    run_op(-32'sd100, 32'sd7, 1'b1);
    run_op(32'sd100, -32'sd7, 1'b1);
    run_op(-32'sd100, -32'sd7, 1'b1);
    run_op(32'h8000_0000, 32'd1, 1'b1);

    req = "R3";
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);

    req = "R5";
    run_op(32'd1234, 32'd0, 1'b0);
    run_op(-32'sd55, 32'd0, 1'b1);
    run_op(32'd3, 32'd10, 1'b0);
    run_op(-32'sd3, -32'sd10, 1'b1);

    req = "R8";   // second start while busy must be ignored
    @(negedge clk);
    dividend = 32'hFFFF_FFFF; divisor = 32'd1; signed_op = 1'b0; start = 1'b1;
    @(negedge clk);
    dividend = 32'd9; divisor = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    req = "R6";   // abort mid-operation
    @(negedge clk);
    dividend = 32'hFFFF_FFFF; divisor = 32'd1; signed_op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (14) @(negedge clk);

    req = "R7";
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0);

    req = "R6";   // abort in the last busy cycle
    @(negedge clk);
    dividend = 32'd77; divisor = 32'd70; signed_op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (4) @(negedge clk);

    req = "R7";
    run_op(32'd77, 32'd70, 1'b0);

    req = "R9";   // start accepted in the done cycle
    @(negedge clk);
    dividend = 32'd40; divisor = 32'd6; signed_op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    dividend = 32'd1000; divisor = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    req = "R1";   // mixed random operands in both modes
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      a = $urandom() >> ($urandom() % 32);
      b = $urandom() >> ($urandom() % 32);
      if (k % 2 == 1) req = "R2"; else req = "R1";
      run_op(a, b, 1'(k % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule